// File: doc/BRIEF.md
# Debounced Wake-Up Detector

This block decides when a sleeping node must be woken. While the low-power enable is set, it watches three sources. The first is the local wake pin, already synchronised to the clock. Either a rising or a falling edge on that pin counts as a wake, but only once the new level has been held for a minimum number of time ticks. The other two sources are the dominant flags of the two bus wires. Each wire has its own debounce window, and either wire alone can wake the node, so a wake still gets through when one wire is broken or shorted. A bus wire that stays dominant for the required window is what a frame with a run of five dominant bits produces.

A detected wake sets a sticky request. The mode controller uses that request to re-enable the external supply, and it drops the request with an explicit clear. All timing is counted on a free-running tick strobe, so the debounce windows stay the same whatever the system clock frequency is. While the block is disabled, the reference level of the wake pin follows the pin. When the block is then enabled, the level present at that moment is taken as the baseline and is not treated as an edge.

Top module: `wake_detect`

## Requirements
- R1: After reset, wakeReq is 0, and it stays 0 until a source has completed its debounce window.
- R2: A rising edge on wakeLvl sets wakeReq at the clock edge that samples the WAKE_MIN_TICKS-th tick during which the high level is still held. One tick fewer does not set it.
- R3: A falling edge on wakeLvl is handled the same way as a rising edge. Once a local wake has fired, the new level becomes the reference, so the next change in either direction is a fresh edge.
- R4: If wakeLvl goes back to the reference level before its window completes, the count starts again from zero and no request is raised.
- R5: canhDom held at 1 for CANH_MIN_TICKS ticks sets wakeReq, even when canlDom is 0. A cycle with canhDom at 0 restarts that count.
- R6: canlDom held at 1 for CANL_MIN_TICKS ticks sets wakeReq, even when canhDom is 0. A cycle with canlDom at 0 restarts that count.
- R7: While lowPwrEn is 0, no source can set wakeReq and all counts are held at zero. The wakeLvl level present when lowPwrEn rises is the reference, and it is not an edge.
- R8: Once set, wakeReq stays at 1 until a cycle with clrReq at 1 and no completing detection. After that cycle it reads 0.
- R9: When a detection completes in the same cycle as clrReq, the detection wins and wakeReq reads 1 afterwards.
- R10: Only cycles with tick at 1 advance a debounce count. Any number of cycles without a tick raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wakeLvl | input | 1 | Synchronised level of the local wake pin |
| canhDom | input | 1 | High-side bus wire reads dominant |
| canlDom | input | 1 | Low-side bus wire reads dominant |
| lowPwrEn | input | 1 | Detection enable; 1 in the low-power modes |
| clrReq | input | 1 | Clears the latched wake request |
| tick | input | 1 | Single-cycle time-base strobe for debouncing |
| wakeReq | output | 1 | Sticky wake request to the mode controller |

## Verification
Two pairs of events can land in the same cycle. In the first, a request clear arrives in the same cycle as the tick that completes a bus wire's window. The bench lets the low-side wire count up to one tick short of its window while a request is already latched. It then drives the completing tick and the clear together, and expects the request to survive. In the second, the high-side and low-side windows overlap and the local pin changes level while the bus is dominant. A behavioural model is compared with the output on every clock, so a lost or doubled set shows up in the very next cycle.

// File: rtl/wake_detect_pkg.sv
package wake_detect_pkg;
  // number of wake sources: local pin, high-side wire, low-side wire
  localparam int unsigned NSRC    = 3;
  localparam int unsigned SRC_LOC = 0;
  localparam int unsigned SRC_HI  = 1;
  localparam int unsigned SRC_LO  = 2;

  // strobes from control to the debounce datapath
  typedef struct packed {
    logic flush;   // hold every debounce count at zero
    logic tickEn;  // advance counts this cycle
  } cntStrobes_t;
endpackage

// File: rtl/wake_detect_dpath.sv
module wake_detect_dpath
  import wake_detect_pkg::*;
#(
  parameter int unsigned WAKE_MIN_TICKS = 8,
  parameter int unsigned CANH_MIN_TICKS = 7,
  parameter int unsigned CANL_MIN_TICKS = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntStrobes_t       strb,
  input  logic [NSRC-1:0]   srcActive,
  output logic [NSRC-1:0]   srcHit
);
  localparam int unsigned MAX_A   = (WAKE_MIN_TICKS > CANH_MIN_TICKS) ? WAKE_MIN_TICKS : CANH_MIN_TICKS;
  localparam int unsigned MAX_LIM = (MAX_A > CANL_MIN_TICKS) ? MAX_A : CANL_MIN_TICKS;
  localparam int unsigned CW      = (MAX_LIM < 2) ? 1 : $clog2(MAX_LIM + 1);

  function automatic int unsigned limOf(int unsigned idx);
    if (idx == SRC_LOC) return WAKE_MIN_TICKS;
    if (idx == SRC_HI)  return CANH_MIN_TICKS;
    return CANL_MIN_TICKS;
  endfunction

  for (genvar g = 0; g < NSRC; g++) begin : gSrc
    localparam int unsigned LIM  = limOf(g);
    localparam logic [CW-1:0] LAST = CW'((LIM == 0) ? 0 : LIM - 1);
    logic [CW-1:0] cnt;

    // the qualifying tick that completes the window
    assign srcHit[g] = strb.tickEn & srcActive[g] & (cnt == LAST);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (strb.flush || !srcActive[g]) begin
        cnt <= '0;
      end else if (strb.tickEn) begin
        cnt <= srcHit[g] ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wake_detect_ctrl.sv
module wake_detect_ctrl
  import wake_detect_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            wakeLvl,
  input  logic            canhDom,
  input  logic            canlDom,
  input  logic            lowPwrEn,
  input  logic            clrReq,
  input  logic            tick,
  input  logic [NSRC-1:0] srcHit,
  output cntStrobes_t     strb,
  output logic [NSRC-1:0] srcActive,
  output logic            wakeReq
);
  logic refLvl;
  logic [NSRC-1:0] rawActive;

  // reference follows the pin while idle and after every local wake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refLvl <= 1'b0;
    end else if (!lowPwrEn || srcHit[SRC_LOC]) begin
      refLvl <= wakeLvl;
    end
  end

  always_comb begin
    rawActive          = '0;
    rawActive[SRC_LOC] = wakeLvl ^ refLvl;
    rawActive[SRC_HI]  = canhDom;
    rawActive[SRC_LO]  = canlDom;
    srcActive          = rawActive & {NSRC{lowPwrEn}};
    strb.flush         = ~lowPwrEn;
    strb.tickEn        = tick & lowPwrEn;
  end

  // a completing detection takes priority over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeReq <= 1'b0;
    end else if (|srcHit) begin
      wakeReq <= 1'b1;
    end else if (clrReq) begin
      wakeReq <= 1'b0;
    end
  end
endmodule

// File: rtl/wake_detect.sv
module wake_detect
  import wake_detect_pkg::*;
#(
  parameter int unsigned WAKE_MIN_TICKS = 8,
  parameter int unsigned CANH_MIN_TICKS = 7,
  parameter int unsigned CANL_MIN_TICKS = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic wakeLvl,
  input  logic canhDom,
  input  logic canlDom,
  input  logic lowPwrEn,
  input  logic clrReq,
  input  logic tick,
  output logic wakeReq
);
  cntStrobes_t     strb;
  logic [NSRC-1:0] srcActive;
  logic [NSRC-1:0] srcHit;

  wake_detect_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wakeLvl   (wakeLvl),
    .canhDom   (canhDom),
    .canlDom   (canlDom),
    .lowPwrEn  (lowPwrEn),
    .clrReq    (clrReq),
    .tick      (tick),
    .srcHit    (srcHit),
    .strb      (strb),
    .srcActive (srcActive),
    .wakeReq   (wakeReq)
  );

  wake_detect_dpath #(
    .WAKE_MIN_TICKS (WAKE_MIN_TICKS),
    .CANH_MIN_TICKS (CANH_MIN_TICKS),
    .CANL_MIN_TICKS (CANL_MIN_TICKS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .srcActive (srcActive),
    .srcHit    (srcHit)
  );
endmodule

// File: rtl/wake_detect_chk.sv
module wake_detect_chk (
  input logic clk,
  input logic rstN,
  input logic wakeLvl,
  input logic canhDom,
  input logic canlDom,
  input logic lowPwrEn,
  input logic clrReq,
  input logic tick,
  input logic wakeReq
);
  AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !lowPwrEn |=> !$rose(wakeReq)); // R7

  AST_TICK_GATES_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> !$rose(wakeReq)); // R10

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wakeReq && !clrReq) |=> wakeReq); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !tick) |=> !wakeReq); // R8

  AST_QUIET_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (!canhDom && !canlDom && !lowPwrEn) |=> !$rose(wakeReq)); // R1
endmodule

bind wake_detect wake_detect_chk u_chk (.*);

// File: tb/wake_detect_bench.sv
module wake_detect_bench;
  localparam int PERIOD = 10;
  localparam int WM = 8;
  localparam int HM = 7;
  localparam int LM = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeLvl = 1'b0, canhDom = 1'b0, canlDom = 1'b0;
  logic lowPwrEn = 1'b0, clrReq = 1'b0, tick = 1'b0;
  logic wakeReq;

  int nVec = 0, nFail = 0;
  string phase = "R1";
  bit done = 1'b0;

  // behavioural reference state
  int mW = 0, mH = 0, mL = 0;
  bit mRef = 1'b0, mReq = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  wake_detect #(.WAKE_MIN_TICKS(WM), .CANH_MIN_TICKS(HM), .CANL_MIN_TICKS(LM)) u_wake_detect (
    .clk(clk), .rstN(rstN), .wakeLvl(wakeLvl), .canhDom(canhDom), .canlDom(canlDom),
    .lowPwrEn(lowPwrEn), .clrReq(clrReq), .tick(tick), .wakeReq(wakeReq)
  );

  always @(posedge clk or negedge rstN) begin
    bit hit;
    if (!rstN) begin
      mW = 0; mH = 0; mL = 0; mRef = 1'b0; mReq = 1'b0;
    end else begin
      hit = 1'b0;
      if (!lowPwrEn) begin
        mRef = wakeLvl; mW = 0; mH = 0; mL = 0;
      end else begin
        if (wakeLvl != mRef) begin
          if (tick) begin
            mW++;
            if (mW >= WM) begin hit = 1'b1; mW = 0; mRef = wakeLvl; end
          end
        end else mW = 0;
        if (canhDom) begin
          if (tick) begin mH++; if (mH >= HM) begin hit = 1'b1; mH = 0; end end
        end else mH = 0;
        if (canlDom) begin
          if (tick) begin mL++; if (mL >= LM) begin hit = 1'b1; mL = 0; end end
        end else mL = 0;
      end
      if (hit) mReq = 1'b1;
      else if (clrReq) mReq = 1'b0;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      nVec++;
      if (wakeReq !== mReq) begin
        nFail++;
        $display("FAIL %s cycle compare: wakeReq=%b expected=%b", phase, wakeReq, mReq);
      end
    end
  end

  task automatic expectReq(input bit e, input string tag);
    #1;
    nVec++;
    if (wakeReq !== e) begin
      nFail++;
      $display("FAIL %s: wakeReq=%b expected=%b", tag, wakeReq, e);
    end
  endtask

  // n ticks, each followed by an idle cycle; ends at a negedge with tick low
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearReq();
    @(negedge clk); clrReq = 1'b1;
    @(negedge clk); clrReq = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    phase = "R1";
    idle(3);
    @(negedge clk); rstN = 1'b1;
    idle(2);
    expectReq(1'b0, "R1 reset state");

    phase = "R7";
    wakeLvl = 1'b1; canhDom = 1'b1;
    ticks(20);
    wakeLvl = 1'b0; ticks(3); wakeLvl = 1'b1; ticks(3);
    expectReq(1'b0, "R7 disabled ignores sources");
    canhDom = 1'b0;
    @(negedge clk); lowPwrEn = 1'b1;
    ticks(20);
    expectReq(1'b0, "R7 level at enable is reference");

    phase = "R4";
    for (int k = 0; k < 3; k++) begin
      wakeLvl = 1'b0; ticks(WM - 1);
      wakeLvl = 1'b1; ticks(1);
    end
    expectReq(1'b0, "R4 revert restarts debounce");

    phase = "R3";
    wakeLvl = 1'b0; ticks(WM - 1);
    expectReq(1'b0, "R3 one tick short");
    ticks(1);
    expectReq(1'b1, "R3 falling edge wake");

    phase = "R8";
    idle(10);
    expectReq(1'b1, "R8 request sticky");
    clearReq();
    expectReq(1'b0, "R8 clear drops request");

    phase = "R2";
    wakeLvl = 1'b1; ticks(WM - 1);
    expectReq(1'b0, "R2 one tick short");
    ticks(1);
    expectReq(1'b1, "R2 rising edge wake");
    clearReq();

    phase = "R10";
    wakeLvl = 1'b0; idle(60);
    expectReq(1'b0, "R10 no tick no count");
    wakeLvl = 1'b1; idle(2);

    phase = "R5";
    canhDom = 1'b1; ticks(HM - 1);
    @(negedge clk); canhDom = 1'b0;
    @(negedge clk); canhDom = 1'b1;
    ticks(HM - 1);
    expectReq(1'b0, "R5 gap restarts high-side count");
    ticks(1);
    expectReq(1'b1, "R5 high-side wire alone wakes");
    canhDom = 1'b0; clearReq();

    phase = "R6";
    canlDom = 1'b1; ticks(LM - 1);
    expectReq(1'b0, "R6 one tick short");
    ticks(1);
    expectReq(1'b1, "R6 low-side wire alone wakes");
    canlDom = 1'b0; clearReq();

    phase = "R9";
    canhDom = 1'b1; ticks(HM);
    canhDom = 1'b0;
    canlDom = 1'b1; ticks(LM - 1);
    expectReq(1'b1, "R9 request latched before collision");
    @(negedge clk); tick = 1'b1; clrReq = 1'b1;
    @(negedge clk); tick = 1'b0; clrReq = 1'b0;
    expectReq(1'b1, "R9 detection beats clear");
    canlDom = 1'b0; clearReq();
    expectReq(1'b0, "R9 later clear");

    phase = "R2";
    canhDom = 1'b1; canlDom = 1'b1; wakeLvl = 1'b0;
    ticks(WM + LM);
    expectReq(1'b1, "R2 overlapping sources");
    canhDom = 1'b0; canlDom = 1'b0;
    @(negedge clk); lowPwrEn = 1'b0;
    clearReq();
    expectReq(1'b0, "R7 clear while disabled");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule